// File: doc/BRIEF.md
# Two-Phase Link Training Sequencer

This block runs the source side of training for a multi-lane serial display link. On a start pulse it configures the sink through an abstract register port. It powers the sink, clears the training pattern, sets link rate and lane count, and clears downspread. It then runs a clock-recovery loop with training pattern 1, followed by a channel-equalization loop with training pattern 2. At the end it clears the pattern on the sink and signals training-complete to the local transmitter.

The register port is a request/acknowledge handshake. Writes carry an address, a byte count and up to four data bytes. A status read returns six bytes together with a success flag. The drive-level arithmetic lives outside the block. The last good status bytes are presented on `status_o`, and the next drive byte is taken from `adj_drive_i` whenever a loop makes an adjustment. All waits are microsecond counts derived from a prescaler whose cycles-per-microsecond value is a parameter.

Top module: `link_train_seq`

## Requirements
- R1: After reset, no request is pending, the transmitter pattern is off (0), the drive byte is 0, and done, training-complete, cr_ok and eq_ok are all low.
- R2: On start, writes are issued in this order. First 0x01 to power register 0x600, but only when the sink revision is 0x11 or higher. Then 0x00 to pattern register 0x102. Then two bytes to 0x100: the rate in the first byte, and the lane count in the second byte with bit 7 set when the revision is 0x11 or higher. Then 0x00 to downspread register 0x107.
- R3: A request stays asserted with a stable address until it is acknowledged. A transfer completes in a cycle where request and acknowledge are both high.
- R4: When the downspread write is accepted, the transmitter pattern becomes 1 (encoding: 0 off, 1 pattern 1, 2 pattern 2) and the drive byte becomes 0. After a 400 µs wait, 0x01 is written to 0x102. Then the drive byte is written, replicated, to 0x103 with a byte count equal to the active lane count.
- R5: Each clock-recovery step waits 100 µs after the last accepted drive write and then reads 6 bytes from 0x202. Lane n's status nibble sits in byte n/2, in the low nibble for even n. The step passes when bit 0 of the nibble is set on every active lane (lanes 0 to count-1). Inactive lanes are ignored.
- R6: Clock recovery gives up when the current drive byte has its max-swing flag (bit 2) set.
- R7: Clock recovery compares the swing field (drive bits 1:0) with the previous step's swing, which starts as no value. Each match increments a repeat count, and any mismatch clears it. The loop gives up on the step that would take the count to 5.
- R8: A failing step that does not give up loads `adj_drive_i` as the new drive byte and writes it to 0x103. After every successful read, `status_o` shows the six bytes, with byte 0 in bits 7:0.
- R9: After clock recovery (whether it passed or not), 0x02 is written to 0x102, and on its acceptance the transmitter pattern becomes 2. Each equalization step waits 400 µs and then reads status. It passes when bit 0 of byte 2 (interlane alignment) is set and bits 2:0 of every active lane's nibble are set.
- R10: Equalization counts its adjustments and gives up on the first failing step that comes after six adjustments. That means at most seven status reads.
- R11: A status read acknowledged with the success flag low ends the current loop immediately, as a failure of that loop.
- R12: Training ends by writing 0x00 to 0x102. One cycle after that write is accepted, done and training-complete pulse for one cycle and the pattern returns to 0. cr_ok and eq_ok keep their results until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| sink_rev_i | input | 8 | Sink revision byte |
| link_rate_i | input | 8 | Link rate code written to the sink |
| lane_cnt_i | input | 3 | Active lanes: 1, 2 or 4 |
| reg_req_o | output | 1 | Register transfer request |
| reg_wr_o | output | 1 | 1 write, 0 read |
| reg_addr_o | output | 16 | Sink register address |
| reg_len_o | output | 3 | Byte count |
| reg_wdata_o | output | 32 | Write bytes, first byte in bits 7:0 |
| reg_ack_i | input | 1 | Transfer acknowledge |
| reg_ok_i | input | 1 | Read succeeded, valid with acknowledge |
| reg_rdata_i | input | 48 | Six status bytes, byte 0 in bits 7:0 |
| status_o | output | 48 | Last good status bytes, for the drive arithmetic |
| adj_drive_i | input | 8 | Next drive byte from the drive arithmetic |
| tx_pat_o | output | 2 | Transmitter pattern: 0 off, 1, 2 |
| drive_o | output | 8 | Drive byte applied to all lanes |
| tx_complete_o | output | 1 | Training-complete pulse to the transmitter |
| cr_ok_o | output | 1 | Clock recovery passed |
| eq_ok_o | output | 1 | Equalization passed |
| done_o | output | 1 | Training finished pulse |

## Verification
The configuration writes follow one another with no gap. The pattern-1 write arrives 400·N+1 cycles after the acknowledge of the downspread write is raised, where N is cycles per microsecond. A clock-recovery read arrives 100·N+1 cycles after its drive write is acknowledged, and an equalization read arrives 400·N+1 cycles after its triggering write. The scoreboard measures each of these gaps from the cycle in which it raised the previous acknowledge. On the cycle after the final acknowledge it checks done, training-complete and the pattern together, and it reads `status_o` in the same cycle to confirm the read was latched. Since every step is paced by the acknowledge, the expected queue sets the order and the cycle counter sets the timing.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam logic [15:0] ADDR_LINK_CFG   = 16'h0100;
  localparam logic [15:0] ADDR_PATTERN    = 16'h0102;
  localparam logic [15:0] ADDR_LANE_DRIVE = 16'h0103;
  localparam logic [15:0] ADDR_SPREAD     = 16'h0107;
  localparam logic [15:0] ADDR_STATUS     = 16'h0202;
  localparam logic [15:0] ADDR_POWER      = 16'h0600;
  localparam logic [7:0]  REV_ENH         = 8'h11;
  localparam logic [7:0]  PWR_ON          = 8'h01;
  localparam int          STATUS_BYTES    = 6;
  localparam int          MAX_SW_BIT      = 2;

  typedef enum logic [1:0] {PAT_OFF = 2'd0, PAT_1 = 2'd1, PAT_2 = 2'd2} lt_pat_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_PDIS, S_CFG, S_SPRD, S_P1_WAIT, S_P1_SET, S_DRV,
    S_CR_WAIT, S_CR_RD, S_P2_SET, S_EQ_WAIT, S_EQ_RD, S_FIN
  } lt_state_e;
endpackage

// File: rtl/lt_us_timer.sv
module lt_us_timer #(
  parameter int CYC_PER_US = 100,
  parameter int US_W       = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  logic [US_W-1:0] us_i,
  output logic            expire_o
);
  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);

  logic             busy_q;
  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  us_q, tgt_q;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == PRE_LAST);
  assign expire_o = busy_q && pre_wrap && (us_q == tgt_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pre_q  <= '0;
      us_q   <= '0;
      tgt_q  <= '0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      pre_q  <= '0;
      us_q   <= '0;
      tgt_q  <= us_i;
    end else if (busy_q) begin
      if (pre_wrap) begin
        pre_q <= '0;
        if (expire_o) busy_q <= 1'b0;
        else          us_q   <= us_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  AST_TMR_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !go_i |=> !expire_o); // R5
  AST_TMR_PRE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PRE_LAST); // R4
endmodule

// File: rtl/lt_lane_check.sv
module lt_lane_check #(
  parameter int NUM_LANES = 4
) (
  input  logic [23:0] stat_i,
  input  logic [2:0]  lanes_i,
  output logic        cr_all_o,
  output logic        eq_all_o
);
  logic [NUM_LANES-1:0] cr_lane, eq_lane;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [3:0] nib;
    logic       act;
    assign nib        = stat_i[(g/2)*8 + (g%2)*4 +: 4];
    assign act        = (3'(g) < lanes_i);
    assign cr_lane[g] = !act || nib[0];
    assign eq_lane[g] = !act || (nib[2:0] == 3'b111);
  end

  assign cr_all_o = &cr_lane;
  assign eq_all_o = (&eq_lane) && stat_i[16];
endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
  import lt_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int P1_WAIT_US = 400,
  parameter int CR_WAIT_US = 100,
  parameter int EQ_WAIT_US = 400,
  parameter int CR_REPEATS = 5,
  parameter int EQ_ADJ_MAX = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [7:0]  sink_rev_i,
  input  logic [7:0]  link_rate_i,
  input  logic [2:0]  lane_cnt_i,
  output logic        reg_req_o,
  output logic        reg_wr_o,
  output logic [15:0] reg_addr_o,
  output logic [2:0]  reg_len_o,
  output logic [31:0] reg_wdata_o,
  input  logic        reg_ack_i,
  input  logic        reg_ok_i,
  input  logic [47:0] reg_rdata_i,
  output logic [47:0] status_o,
  input  logic [7:0]  adj_drive_i,
  output logic [1:0]  tx_pat_o,
  output logic [7:0]  drive_o,
  output logic        tx_complete_o,
  output logic        cr_ok_o,
  output logic        eq_ok_o,
  output logic        done_o
);
  localparam int MAX_US = (P1_WAIT_US > EQ_WAIT_US) ?
                          ((P1_WAIT_US > CR_WAIT_US) ? P1_WAIT_US : CR_WAIT_US) :
                          ((EQ_WAIT_US > CR_WAIT_US) ? EQ_WAIT_US : CR_WAIT_US);
  localparam int US_W  = $clog2(MAX_US + 1);
  localparam int CNT_W = $clog2(EQ_ADJ_MAX + 2);
  localparam int REP_W = $clog2(CR_REPEATS + 1);

  lt_state_e        state_q;
  logic             enh_q, eq_phase_q;
  logic [7:0]       rate_q, drive_q;
  logic [2:0]       lanes_q, prev_sw_q;
  logic [REP_W-1:0] cr_rep_q;
  logic [CNT_W-1:0] eq_adj_q;
  logic             cr_ok_q, eq_ok_q, done_q, txc_q;
  lt_pat_e          pat_q;
  logic [47:0]      status_q;

  logic             hs, tmr_go, tmr_exp, cr_all, eq_all, sw_same, cr_stop, eq_stop;
  logic [US_W-1:0]  tmr_us;
  logic [7:0]       lane_byte;

  // register port, driven from state
  assign lane_byte = {enh_q, 4'b0000, lanes_q};

  always_comb begin
    reg_req_o   = 1'b1;
    reg_wr_o    = 1'b1;
    reg_addr_o  = ADDR_PATTERN;
    reg_len_o   = 3'd1;
    reg_wdata_o = '0;
    unique case (state_q)
      S_PWR:    begin reg_addr_o = ADDR_POWER; reg_wdata_o = {24'h0, PWR_ON}; end
      S_PDIS:   reg_wdata_o = 32'h0;
      S_CFG:    begin
                  reg_addr_o  = ADDR_LINK_CFG;
                  reg_len_o   = 3'd2;
                  reg_wdata_o = {16'h0, lane_byte, rate_q};
                end
      S_SPRD:   reg_addr_o = ADDR_SPREAD;
      S_P1_SET: reg_wdata_o = 32'(PAT_1);
      S_DRV:    begin
                  reg_addr_o  = ADDR_LANE_DRIVE;
                  reg_len_o   = lanes_q;
                  reg_wdata_o = {4{drive_q}};
                end
      S_CR_RD, S_EQ_RD: begin
                  reg_wr_o   = 1'b0;
                  reg_addr_o = ADDR_STATUS;
                  reg_len_o  = 3'(STATUS_BYTES);
                end
      S_P2_SET: reg_wdata_o = 32'(PAT_2);
      S_FIN:    reg_wdata_o = 32'h0;
      default:  reg_req_o = 1'b0;
    endcase
  end

  assign hs = reg_req_o && reg_ack_i;

  // wait timer
  assign tmr_go = hs && (state_q inside {S_SPRD, S_DRV, S_P2_SET});
  always_comb begin
    if (state_q == S_SPRD)                   tmr_us = US_W'(P1_WAIT_US);
    else if (state_q == S_DRV && !eq_phase_q) tmr_us = US_W'(CR_WAIT_US);
    else                                     tmr_us = US_W'(EQ_WAIT_US);
  end

  lt_us_timer #(.CYC_PER_US(CYC_PER_US), .US_W(US_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (tmr_go),
    .us_i     (tmr_us),
    .expire_o (tmr_exp)
  );

  lt_lane_check #(.NUM_LANES(4)) u_chk (
    .stat_i   (reg_rdata_i[23:0]),
    .lanes_i  (lanes_q),
    .cr_all_o (cr_all),
    .eq_all_o (eq_all)
  );

  // give-up rules
  assign sw_same = !prev_sw_q[2] && (prev_sw_q[1:0] == drive_q[1:0]);
  assign cr_stop = !reg_ok_i || cr_all || drive_q[MAX_SW_BIT] ||
                   (sw_same && (cr_rep_q == REP_W'(CR_REPEATS - 1)));
  assign eq_stop = !reg_ok_i || eq_all || (eq_adj_q >= CNT_W'(EQ_ADJ_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      enh_q      <= 1'b0;
      eq_phase_q <= 1'b0;
      rate_q     <= '0;
      drive_q    <= '0;
      lanes_q    <= '0;
      prev_sw_q  <= 3'b100;
      cr_rep_q   <= '0;
      eq_adj_q   <= '0;
      cr_ok_q    <= 1'b0;
      eq_ok_q    <= 1'b0;
      done_q     <= 1'b0;
      txc_q      <= 1'b0;
      pat_q      <= PAT_OFF;
      status_q   <= '0;
    end else begin
      done_q <= 1'b0;
      txc_q  <= 1'b0;
      if ((state_q inside {S_CR_RD, S_EQ_RD}) && hs && reg_ok_i) status_q <= reg_rdata_i;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          enh_q      <= (sink_rev_i >= REV_ENH);
          rate_q     <= link_rate_i;
          lanes_q    <= lane_cnt_i;
          eq_phase_q <= 1'b0;
          prev_sw_q  <= 3'b100;
          cr_rep_q   <= '0;
          eq_adj_q   <= '0;
          cr_ok_q    <= 1'b0;
          eq_ok_q    <= 1'b0;
          state_q    <= (sink_rev_i >= REV_ENH) ? S_PWR : S_PDIS;
        end
        S_PWR:  if (hs) state_q <= S_PDIS;
        S_PDIS: if (hs) state_q <= S_CFG;
        S_CFG:  if (hs) state_q <= S_SPRD;
        S_SPRD: if (hs) begin
          pat_q   <= PAT_1;
          drive_q <= '0;
          state_q <= S_P1_WAIT;
        end
        S_P1_WAIT: if (tmr_exp) state_q <= S_P1_SET;
        S_P1_SET:  if (hs) state_q <= S_DRV;
        S_DRV:     if (hs) state_q <= eq_phase_q ? S_EQ_WAIT : S_CR_WAIT;
        S_CR_WAIT: if (tmr_exp) state_q <= S_CR_RD;
        S_CR_RD: if (hs) begin
          if (cr_stop) begin
            cr_ok_q <= reg_ok_i && cr_all;
            state_q <= S_P2_SET;
          end else begin
            cr_rep_q  <= sw_same ? cr_rep_q + 1'b1 : '0;
            prev_sw_q <= {1'b0, drive_q[1:0]};
            drive_q   <= adj_drive_i;
            state_q   <= S_DRV;
          end
        end
        S_P2_SET: if (hs) begin
          pat_q      <= PAT_2;
          eq_phase_q <= 1'b1;
          state_q    <= S_EQ_WAIT;
        end
        S_EQ_WAIT: if (tmr_exp) state_q <= S_EQ_RD;
        S_EQ_RD: if (hs) begin
          if (eq_stop) begin
            eq_ok_q <= reg_ok_i && eq_all;
            state_q <= S_FIN;
          end else begin
            eq_adj_q <= eq_adj_q + 1'b1;
            drive_q  <= adj_drive_i;
            state_q  <= S_DRV;
          end
        end
        S_FIN: if (hs) begin
          pat_q   <= PAT_OFF;
          done_q  <= 1'b1;
          txc_q   <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign status_o      = status_q;
  assign tx_pat_o      = pat_q;
  assign drive_o       = drive_q;
  assign tx_complete_o = txc_q;
  assign cr_ok_o       = cr_ok_q;
  assign eq_ok_o       = eq_ok_q;
  assign done_o        = done_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_DONE_PAT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> tx_pat_o == PAT_OFF && tx_complete_o && !reg_req_o); // R12
  AST_OK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_IDLE && !start_i |=> $stable(cr_ok_o) && $stable(eq_ok_o)); // R12
  AST_CR_REP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_rep_q < REP_W'(CR_REPEATS)); // R7
  AST_EQ_ADJ_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_adj_q <= CNT_W'(EQ_ADJ_MAX)); // R10
  AST_PAT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pat_o != 2'd3); // R4
  AST_MAXSW_NO_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_CR_RD && hs && drive_o[MAX_SW_BIT] |=> state_q == S_P2_SET); // R6
endmodule

// File: tb/sim_link_train_seq.sv
module sim_link_train_seq;
  localparam int CPU  = 2;
  localparam int G_P1 = 400 * CPU + 1;
  localparam int G_CR = 100 * CPU + 1;
  localparam int G_EQ = 400 * CPU + 1;

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [2:0]  len;
    logic [31:0] data;
    int          gap;
    int          pat;
    bit          last;
    logic [47:0] rd;
    bit          ok;
    logic [7:0]  adj;
    string       req;
  } item_t;

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [7:0]  sink_rev_i = '0, link_rate_i = '0, adj_drive_i = '0;
  logic [2:0]  lane_cnt_i = '0;
  logic        reg_req_o, reg_wr_o, reg_ack_i = 1'b0, reg_ok_i = 1'b0;
  logic [15:0] reg_addr_o;
  logic [2:0]  reg_len_o;
  logic [31:0] reg_wdata_o;
  logic [47:0] reg_rdata_i = '0, status_o;
  logic [1:0]  tx_pat_o;
  logic [7:0]  drive_o;
  logic        tx_complete_o, cr_ok_o, eq_ok_o, done_o;

  int    checks = 0, errors = 0, cyc = 0, last_ack = 0;
  bit    finished = 1'b0;
  item_t q[$];

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  link_train_seq #(.CYC_PER_US(CPU)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sink_rev_i(sink_rev_i),
    .link_rate_i(link_rate_i), .lane_cnt_i(lane_cnt_i), .reg_req_o(reg_req_o),
    .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o), .reg_len_o(reg_len_o),
    .reg_wdata_o(reg_wdata_o), .reg_ack_i(reg_ack_i), .reg_ok_i(reg_ok_i),
    .reg_rdata_i(reg_rdata_i), .status_o(status_o), .adj_drive_i(adj_drive_i),
    .tx_pat_o(tx_pat_o), .drive_o(drive_o), .tx_complete_o(tx_complete_o),
    .cr_ok_o(cr_ok_o), .eq_ok_o(eq_ok_o), .done_o(done_o)
  );

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pw(input logic [15:0] a, input logic [2:0] l, input logic [31:0] d,
                    input int gap, input int pat, input bit last, input string req);
    item_t e;
    e.wr = 1; e.addr = a; e.len = l; e.data = d; e.gap = gap; e.pat = pat;
    e.last = last; e.rd = '0; e.ok = 1; e.adj = '0; e.req = req;
    q.push_back(e);
  endtask

  task automatic pr(input logic [47:0] rd, input bit ok, input logic [7:0] adj,
                    input int gap, input int pat, input string req);
    item_t e;
    e.wr = 0; e.addr = 16'h0202; e.len = 3'd6; e.data = '0; e.gap = gap; e.pat = pat;
    e.last = 0; e.rd = rd; e.ok = ok; e.adj = adj; e.req = req;
    q.push_back(e);
  endtask

  // expected start sequence, built from R2 and R4
  task automatic cfg_seq(input logic [7:0] rev, input logic [2:0] lanes, input logic [7:0] rate);
    logic [7:0] lb;
    lb = {5'b0, lanes};
    if (rev >= 8'h11) begin
      lb[7] = 1'b1;
      pw(16'h0600, 3'd1, 32'h01, 0, 0, 0, "R2");
    end
    pw(16'h0102, 3'd1, 32'h00, 0, 0, 0, "R2");
    pw(16'h0100, 3'd2, {16'h0, lb, rate}, 0, 0, 0, "R2");
    pw(16'h0107, 3'd1, 32'h00, 0, 0, 0, "R2");
    pw(16'h0102, 3'd1, 32'h01, G_P1, 1, 0, "R4");
    pw(16'h0103, lanes, 32'h0, 0, 1, 0, "R4");
  endtask

  task automatic run(input logic [7:0] rev, input logic [2:0] lanes, input logic [7:0] rate,
                     input bit exp_cr, input bit exp_eq, input string req);
    sink_rev_i = rev; lane_cnt_i = lanes; link_rate_i = rate;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(cr_ok_o == 0 && eq_ok_o == 0, "R12", "flags cleared at start", {cr_ok_o, eq_ok_o}, 0);
    while (!done_o) @(negedge clk_i);
    chk(cr_ok_o == exp_cr, req, "cr_ok", cr_ok_o, exp_cr);
    chk(eq_ok_o == exp_eq, req, "eq_ok", eq_ok_o, exp_eq);
    repeat (20) @(negedge clk_i);
    chk(cr_ok_o == exp_cr && eq_ok_o == exp_eq && !done_o, "R12", "flags held after done",
        {done_o, cr_ok_o, eq_ok_o}, {1'b0, exp_cr, exp_eq});
    chk(q.size() == 0, req, "transfers left over", q.size(), 0);
  endtask

  // scoreboard monitor and register responder
  initial begin
    item_t e;
    logic [15:0] a0;
    forever begin
      @(negedge clk_i);
      if (rst_ni && reg_req_o) begin
        if (q.size() == 0) begin
          chk(0, "R2", "unexpected request", reg_addr_o, 0);
          e.wr = reg_wr_o; e.addr = reg_addr_o; e.len = reg_len_o; e.data = reg_wdata_o;
          e.gap = 0; e.pat = -1; e.last = 0; e.rd = '0; e.ok = 0; e.adj = '0; e.req = "R2";
        end else begin
          e = q.pop_front();
        end
        chk(reg_wr_o == e.wr && reg_addr_o == e.addr && reg_len_o == e.len, e.req,
            "request kind/addr/len", {reg_wr_o, reg_addr_o, reg_len_o}, {e.wr, e.addr, e.len});
        if (e.wr)
          chk(reg_wdata_o == e.data, e.req, "write data", reg_wdata_o, e.data);
        if (e.gap != 0)
          chk(cyc - last_ack == e.gap, e.req, "cycles since last ack", cyc - last_ack, e.gap);
        if (e.pat >= 0)
          chk(tx_pat_o == 2'(e.pat), e.req, "tx pattern", tx_pat_o, e.pat);
        if (e.addr == 16'h0103)
          chk(drive_o == e.data[7:0], "R8", "drive output", drive_o, e.data[7:0]);
        a0 = reg_addr_o;
        repeat (2) begin
          @(negedge clk_i);
          chk(reg_req_o && reg_addr_o == a0, "R3", "request held", {reg_req_o, reg_addr_o}, {1'b1, a0});
        end
        reg_rdata_i = e.rd; reg_ok_i = e.ok; adj_drive_i = e.adj; reg_ack_i = 1'b1;
        last_ack = cyc;
        @(negedge clk_i);
        reg_ack_i = 1'b0;
        if (!e.wr && e.ok)
          chk(status_o == e.rd, "R8", "status latched", status_o, e.rd);
        if (e.last) begin
          chk(done_o && tx_complete_o && tx_pat_o == 0, "R12", "done/complete/pattern",
              {done_o, tx_complete_o, tx_pat_o}, 4'b1100);
          @(negedge clk_i);
          chk(!done_o && !tx_complete_o, "R12", "single-cycle pulse", {done_o, tx_complete_o}, 0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!reg_req_o && tx_pat_o == 0 && drive_o == 0 && !done_o && !tx_complete_o &&
        !cr_ok_o && !eq_ok_o, "R1", "reset state",
        {reg_req_o, tx_pat_o, drive_o, done_o, tx_complete_o, cr_ok_o, eq_ok_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // S1: enhanced sink, 2 lanes, one adjustment in each loop, both pass (R5 R8 R9)
    cfg_seq(8'h12, 3'd2, 8'h0A);
    pr(48'h00_0000_01, 1, 8'h01, G_CR, 1, "R5");          // lane1 missing CR
    pw(16'h0103, 3'd2, 32'h01010101, 0, 1, 0, "R8");
    pr(48'h00_0000_11, 1, 8'h00, G_CR, 1, "R5");
    pw(16'h0102, 3'd1, 32'h02, 0, 1, 0, "R9");
    pr(48'h00_0000_0077, 1, 8'h09, G_EQ, 2, "R9");        // no interlane align
    pw(16'h0103, 3'd2, 32'h09090909, 0, 2, 0, "R8");
    pr(48'h00_0001_0077, 1, 8'h00, G_EQ, 2, "R9");
    pw(16'h0102, 3'd1, 32'h00, 0, 2, 1, "R12");
    run(8'h12, 3'd2, 8'h0A, 1, 1, "R9");

    // S2: old sink, 1 lane, swing never changes; R7 then R10
    cfg_seq(8'h10, 3'd1, 8'h06);
    for (int i = 0; i < 6; i++) begin
      pr(48'h0, 1, 8'h00, G_CR, 1, "R7");
      if (i < 5) pw(16'h0103, 3'd1, 32'h0, 0, 1, 0, "R7");
    end
    pw(16'h0102, 3'd1, 32'h02, 0, 1, 0, "R7");
    for (int i = 0; i < 7; i++) begin
      pr(48'h0, 1, 8'h00, G_EQ, 2, "R10");
      if (i < 6) pw(16'h0103, 3'd1, 32'h0, 0, 2, 0, "R10");
    end
    pw(16'h0102, 3'd1, 32'h00, 0, 2, 1, "R12");
    run(8'h10, 3'd1, 8'h06, 0, 0, "R10");

    // S3: 4 lanes, max swing stops CR (R6); failed EQ read ends EQ (R11)
    cfg_seq(8'h11, 3'd4, 8'h0A);
    pr(48'h00_0001_11, 1, 8'h07, G_CR, 1, "R5");          // lane3 missing CR
    pw(16'h0103, 3'd4, 32'h07070707, 0, 1, 0, "R8");
    pr(48'h00_0001_11, 1, 8'h00, G_CR, 1, "R6");
    pw(16'h0102, 3'd1, 32'h02, 0, 1, 0, "R6");
    pr(48'h00_0001_7777, 0, 8'h00, G_EQ, 2, "R11");
    pw(16'h0102, 3'd1, 32'h00, 0, 2, 1, "R11");
    run(8'h11, 3'd4, 8'h0A, 0, 0, "R6");

    // S4: 1 lane, failed CR read (R11), EQ passes with inactive lanes clear (R9)
    cfg_seq(8'h11, 3'd1, 8'h06);
    pr(48'h00_0000_11, 0, 8'h00, G_CR, 1, "R11");
    pw(16'h0102, 3'd1, 32'h02, 0, 1, 0, "R11");
    pr(48'h00_0001_0007, 1, 8'h00, G_EQ, 2, "R9");
    pw(16'h0102, 3'd1, 32'h00, 0, 2, 1, "R12");
    run(8'h11, 3'd1, 8'h06, 0, 1, "R11");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule